// File: doc/BRIEF.md
# Wired-Interrupt to Message Bridge

This block collects a large set of wired interrupt lines and turns each firing into one message-signalled interrupt write. The lines are grouped in nodes of 128. Each line has a trigger-type bit, which selects level-high or rising-edge behaviour, and a vector register that holds the event ID and device ID the message carries. Software programs both through a simple 32-bit register port. When a line fires, the block records it as pending and later sends exactly one message for it. A separate write-one-to-clear window, indexed by global pin number, removes the pending state again.

Messages leave on a valid/ready port. The port presents the device ID, the event ID and a doorbell address that is fixed at build time. When several lines are waiting at once, a round-robin arbiter picks one of them for each message slot. Global pin numbers start at 64, because 0 to 63 are reserved. Pin `irq_in[i]` is global pin `64 + i`, which is node `i/128 + 1`, local pin `i%128`. `NUM_NODES` may range from 1 to 9.

Top module: `wmsi_bridge`

## Requirements
- R1: After reset, `msi_valid` is low and every pending bit, trigger-type bit and vector register reads back as zero.
- R2: The vector register of local pin p in node n is at n×0x1000 + 0x200 + 4p. Bits [21:12] hold the event ID and bits [11:0] hold the device ID. Bits [31:22] read as zero.
- R3: The trigger-type word k of node n is at n×0x1000 + 4k, for k = 0..3. Local pin p uses word p/32, bit p%32. A 1 selects level-high triggering and a 0 selects rising-edge triggering, which is the reset default.
- R4: A rising-edge pin that sees a 0→1 transition becomes pending and produces exactly one message. Further edges before it is cleared are merged and produce no message.
- R5: A level pin produces one message while high, then none until it is cleared. If it is still high when cleared, exactly one new message follows.
- R6: The clear window starts at 0xA000. Global pin g uses word g/32, bit g%32. Writing 1 to a bit clears that pin's pending state, and writing 0 has no effect. A read of the window returns the pending bits, with reserved pins reading 0.
- R7: `msi_data` is {device ID[21:10], event ID[9:0]} taken from the pin's vector register. `msi_addr` is the constant `DOORBELL`. While `msi_valid` is high and `msi_ready` is low, both the valid and the data stay unchanged.
- R8: Among pending pins not yet sent, the grant goes to the lowest index at or above the round-robin pointer, wrapping around to index 0. After each grant the pointer moves to the granted index + 1.
- R9: When a line goes high and is sampled at clock edge 1, and nothing else is waiting, `msi_valid` rises at clock edge 4.
- R10: The following accesses are unmapped: node fields of 0 or above `NUM_NODES`, unused offsets within a node, clear words beyond the last pin, and any address with bits [1:0] not equal to zero. Reads of unmapped addresses return zero and writes to them change nothing.
- R11: Read data appears on `reg_rdata` after the clock edge that samples `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_NODES×128 | Wired interrupt lines, bit i is global pin 64+i |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| msi_valid | output | 1 | Message write is offered |
| msi_ready | input | 1 | Message write is accepted |
| msi_addr | output | 32 | Fixed doorbell address |
| msi_data | output | 22 | {device ID, event ID} |

## Verification
The message for a raised line is due at the fourth rising edge after the line is first sampled: two sampling stages, the pending register and the output register. The bench checks that `msi_valid` is still low after edge three and high after edge four. Register reads are due one edge after the strobe, so every read is issued at a falling edge and sampled at the next falling edge. For ignored stimuli, such as merged edges, zero-writes to clear bits and writes to unmapped addresses, the bench waits well past the four-edge delivery window and then reads the pending bits or the affected registers back through the register port. The arbitration order is checked by raising three lines in the same cycle and comparing each accepted message with the order the pointer predicts.

// File: rtl/wmsi_pkg.sv
package wmsi_pkg;
    localparam int PINS_PER_NODE = 128;
    localparam int RSVD_PINS     = 64;
    localparam int EVT_W         = 10;
    localparam int DEV_W         = 12;
    localparam int VEC_W         = EVT_W + DEV_W;
    localparam int WORD_PINS     = 32;

    localparam logic [3:0] CLR_PAGE = 4'hA;
    localparam logic [2:0] VEC_PAGE = 3'b001;

    // stored layout: event ID above device ID
    typedef struct packed {
        logic [EVT_W-1:0] evt;
        logic [DEV_W-1:0] dev;
    } vec_t;

    // message layout: device ID above event ID
    typedef struct packed {
        logic [DEV_W-1:0] dev;
        logic [EVT_W-1:0] evt;
    } msi_pl_t;

    typedef enum logic [1:0] {SEL_NONE, SEL_TYPE, SEL_VEC, SEL_CLR} sel_e;

    function automatic msi_pl_t to_payload(input vec_t v);
        msi_pl_t p;
        p.dev = v.dev;
        p.evt = v.evt;
        return p;
    endfunction

    function automatic int clr_word_count(input int npin);
        return (RSVD_PINS + npin + WORD_PINS - 1) / WORD_PINS;
    endfunction
endpackage

// File: rtl/wmsi_regs.sv
module wmsi_regs
    import wmsi_pkg::*;
#(
    parameter int NUM_NODES = 2,
    localparam int NPIN = NUM_NODES * PINS_PER_NODE,
    localparam int TW_W = $clog2(NPIN / WORD_PINS),
    localparam int PIX_W = $clog2(NPIN),
    localparam int CW_N = clr_word_count(NPIN)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        rd_en,
    input  logic [15:0]                 addr,
    input  logic [31:0]                 wdata,
    output logic [31:0]                 rdata,
    input  logic [NPIN-1:0]             pend_i,
    output logic [NPIN-1:0]             lvl_sel_o,
    output vec_t [NPIN-1:0]             vec_tbl_o,
    output logic [NPIN-1:0]             clr_o
);
    sel_e             sel;
    logic             node_ok;
    logic [TW_W-1:0]  tw;
    logic [PIX_W-1:0] vix;
    logic [9:0]       cw;
    logic [NPIN-1:0]  lvl_q;
    vec_t [NPIN-1:0]  vec_q;
    logic [31:0]      rd_val;

    // address decode
    always_comb begin
        sel     = SEL_NONE;
        node_ok = (addr[15:12] != 4'd0) && (int'(addr[15:12]) <= NUM_NODES);
        tw      = TW_W'((int'(addr[15:12]) - 1) * 4 + int'(addr[3:2]));
        vix     = PIX_W'((int'(addr[15:12]) - 1) * PINS_PER_NODE + int'(addr[8:2]));
        cw      = addr[11:2];
        if (addr[1:0] == 2'b00) begin
            if (node_ok && addr[11:4] == 8'd0)
                sel = SEL_TYPE;
            else if (node_ok && addr[11:9] == VEC_PAGE)
                sel = SEL_VEC;
            else if (addr[15:12] == CLR_PAGE && int'(cw) < CW_N)
                sel = SEL_CLR;
        end
    end

    // configuration storage
    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            vec_q <= '0;
        end else if (wr_en) begin
            if (sel == SEL_TYPE)
                lvl_q[tw*WORD_PINS +: WORD_PINS] <= wdata;
            if (sel == SEL_VEC)
                vec_q[vix] <= vec_t'(wdata[VEC_W-1:0]);
        end
    end

    // clear pulses and read mux over the global-pin window
    always_comb begin
        clr_o  = '0;
        rd_val = '0;
        if (sel == SEL_TYPE)
            rd_val = lvl_q[tw*WORD_PINS +: WORD_PINS];
        else if (sel == SEL_VEC)
            rd_val = {{(32-VEC_W){1'b0}}, vec_q[vix]};
        for (int w = 0; w < CW_N; w++) begin
            for (int b = 0; b < WORD_PINS; b++) begin
                if (w * WORD_PINS + b >= RSVD_PINS && w * WORD_PINS + b < RSVD_PINS + NPIN) begin
                    if (sel == SEL_CLR && int'(cw) == w) begin
                        clr_o[w*WORD_PINS + b - RSVD_PINS] = wr_en & wdata[b];
                        rd_val[b] = pend_i[w*WORD_PINS + b - RSVD_PINS];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= rd_en ? rd_val : '0;
    end

    assign lvl_sel_o = lvl_q;
    assign vec_tbl_o = vec_q;

    // R10: an unmapped read returns zero on the following cycle
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == SEL_NONE) |=> (rdata == 32'd0));
endmodule

// File: rtl/wmsi_pend.sv
module wmsi_pend
    import wmsi_pkg::*;
#(
    parameter int NPIN = 256,
    localparam int IW = $clog2(NPIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] irq_in,
    input  logic [NPIN-1:0] lvl_sel,
    input  logic [NPIN-1:0] clr,
    input  logic            take,
    input  logic [IW-1:0]   take_idx,
    output logic [NPIN-1:0] pend_o,
    output logic [NPIN-1:0] req_o
);
    logic [NPIN-1:0] smp0, smp1, prev;
    logic [NPIN-1:0] trig, take_vec;
    logic [NPIN-1:0] pend_q, sent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp0 <= '0;
            smp1 <= '0;
            prev <= '0;
        end else begin
            smp0 <= irq_in;
            smp1 <= smp0;
            prev <= smp1;
        end
    end

    always_comb begin
        trig     = (lvl_sel & smp1) | (~lvl_sel & smp1 & ~prev);
        take_vec = '0;
        for (int i = 0; i < NPIN; i++)
            take_vec[i] = take && (take_idx == IW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            sent_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | trig;
            sent_q <= (sent_q | take_vec) & ~clr;
        end
    end

    assign pend_o = pend_q;
    assign req_o  = pend_q & ~sent_q;

    // R4: a pin marked as sent is always still pending
    p_sent_pend_r4: assert property (@(posedge clk) disable iff (rst)
        (sent_q & ~pend_q) == '0);

    // R4: only a waiting, unsent pin is ever taken
    p_take_req_r4: assert property (@(posedge clk) disable iff (rst)
        take |-> req_o[take_idx]);
endmodule

// File: rtl/wmsi_rr_arb.sv
module wmsi_rr_arb #(
    parameter int N = 256,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          gnt_valid,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr;
    logic          lo_hit, hi_hit;
    logic [IW-1:0] lo_idx, hi_idx;

    always_comb begin
        lo_hit = 1'b0;
        hi_hit = 1'b0;
        lo_idx = '0;
        hi_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                lo_hit = 1'b1;
                lo_idx = IW'(i);
                if (IW'(i) >= ptr) begin
                    hi_hit = 1'b1;
                    hi_idx = IW'(i);
                end
            end
        end
        gnt_valid = lo_hit;
        gnt_idx   = hi_hit ? hi_idx : lo_idx;
    end

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= '0;
        else if (take)
            ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
    end

    // R8: a grant always names a requesting pin
    p_grant_req_r8: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> req[gnt_idx]);
endmodule

// File: rtl/wmsi_bridge.sv
module wmsi_bridge
    import wmsi_pkg::*;
#(
    parameter int          NUM_NODES = 2,
    parameter logic [31:0] DOORBELL  = 32'h0001_0040,
    localparam int NPIN = NUM_NODES * PINS_PER_NODE,
    localparam int IW = $clog2(NPIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPIN-1:0]  irq_in,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [15:0]      reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             msi_valid,
    input  logic             msi_ready,
    output logic [31:0]      msi_addr,
    output logic [VEC_W-1:0] msi_data
);
    logic [NPIN-1:0] lvl_sel, clr, pend, req;
    vec_t [NPIN-1:0] vec_tbl;
    logic            gnt_valid, take;
    logic [IW-1:0]   gnt_idx;
    msi_pl_t         out_q;
    logic            valid_q;

    wmsi_regs #(.NUM_NODES(NUM_NODES)) regs_i (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .rd_en(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .pend_i(pend), .lvl_sel_o(lvl_sel), .vec_tbl_o(vec_tbl), .clr_o(clr)
    );

    wmsi_pend #(.NPIN(NPIN)) pend_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .lvl_sel(lvl_sel), .clr(clr),
        .take(take), .take_idx(gnt_idx), .pend_o(pend), .req_o(req)
    );

    wmsi_rr_arb #(.N(NPIN)) arb_i (
        .clk(clk), .rst(rst), .req(req), .take(take),
        .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
    );

    assign take = gnt_valid && (!valid_q || msi_ready);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else if (!valid_q || msi_ready) begin
            valid_q <= gnt_valid;
            if (gnt_valid)
                out_q <= to_payload(vec_tbl[gnt_idx]);
        end
    end

    assign msi_valid = valid_q;
    assign msi_data  = out_q;
    assign msi_addr  = DOORBELL;

    // R7: an offered message is held until accepted
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
        (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_data)));
endmodule

// File: tb/wmsi_bridge_tb_top.sv
module wmsi_bridge_tb_top;
    localparam int NN   = 2;
    localparam int NPIN = NN * 128;
    localparam logic [31:0] DB = 32'h0001_0040;

    logic            clk = 1'b0;
    logic            rst;
    logic [NPIN-1:0] irq_in;
    logic            reg_wr, reg_rd, msi_ready, msi_valid;
    logic [15:0]     reg_addr;
    logic [31:0]     reg_wdata, reg_rdata, msi_addr;
    logic [21:0]     msi_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    wmsi_bridge #(.NUM_NODES(NN), .DOORBELL(DB)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr),
        .msi_data(msi_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [21:0] vecv(input int i);
        logic [9:0]  e = 10'((i * 37 + 3) % 1024);
        logic [11:0] dv = 12'((i * 53 + 256) % 4096);
        return {e, dv};
    endfunction

    function automatic logic [21:0] msgv(input int i);
        logic [21:0] v = vecv(i);
        return {v[11:0], v[21:12]};
    endfunction

    function automatic logic [15:0] vec_addr(input int i);
        return 16'((i / 128 + 1) * 4096 + 16'h200 + (i % 128) * 4);
    endfunction

    function automatic logic [15:0] type_addr(input int i);
        return 16'((i / 128 + 1) * 4096 + ((i % 128) / 32) * 4);
    endfunction

    function automatic logic [15:0] clr_addr(input int i);
        return 16'(16'hA000 + ((i + 64) / 32) * 4);
    endfunction

    function automatic logic [31:0] clr_bit(input int i);
        return 32'd1 << ((i + 64) % 32);
    endfunction

    task automatic get_msg(output logic [21:0] d, output bit ok);
        ok = 1'b0;
        for (int t = 0; t < 20; t++) begin
            if (msi_valid) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        d = msi_data;
        if (ok) begin
            msi_ready = 1'b1;
            @(negedge clk);
            msi_ready = 1'b0;
        end
    endtask

    task automatic quiet(input string tag, input int n);
        logic seen = 1'b0;
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            seen = seen | msi_valid;
        end
        chk(tag, {31'd0, seen}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [21:0] d;
        bit ok;
        int order [3];

        rst = 1'b1; irq_in = '0; reg_wr = 0; reg_rd = 0; msi_ready = 0;
        reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 msi_valid", {31'd0, msi_valid}, 32'd0);
        for (int w = 0; w < 10; w++) begin
            rd(16'(16'hA000 + w * 4), r);
            chk("R1 pending word", r, 32'd0);
        end
        rd(16'h1200, r); chk("R1 vector", r, 32'd0);
        rd(16'h2008, r); chk("R1 type", r, 32'd0);

        // R2/R11 vector sweep over every pin
        for (int i = 0; i < NPIN; i++)
            wr(vec_addr(i), {10'h3FF, vecv(i)});
        for (int i = 0; i < NPIN; i++) begin
            rd(vec_addr(i), r);
            chk("R2 R11 vector readback", r, {10'd0, vecv(i)});
        end

        // R3 type words
        for (int k = 0; k < 8; k++)
            wr(16'((k / 4 + 1) * 4096 + (k % 4) * 4), 32'h9E37_79B9 * (k + 1));
        for (int k = 0; k < 8; k++) begin
            rd(16'((k / 4 + 1) * 4096 + (k % 4) * 4), r);
            chk("R3 type readback", r, 32'h9E37_79B9 * (k + 1));
            wr(16'((k / 4 + 1) * 4096 + (k % 4) * 4), 32'd0);
        end

        // R10 unmapped reads and writes
        rd(16'h0200, r); chk("R10 node0", r, 32'd0);
        rd(16'h3200, r); chk("R10 node3", r, 32'd0);
        rd(16'h1100, r); chk("R10 hole", r, 32'd0);
        rd(16'h1010, r); chk("R10 past type", r, 32'd0);
        rd(16'hA028, r); chk("R10 past clear", r, 32'd0);
        rd(16'h1202, r); chk("R10 misaligned", r, 32'd0);
        wr(16'h3204, 32'hFFFF_FFFF);
        rd(16'h1204, r); chk("R10 node3 write", r, {10'd0, vecv(1)});
        wr(16'h0000, 32'hFFFF_FFFF);
        rd(16'h1000, r); chk("R10 node0 write", r, 32'd0);
        wr(16'h1206, 32'hFFFF_FFFF);
        rd(16'h1204, r); chk("R10 misaligned write", r, {10'd0, vecv(1)});

        // R9 latency and R7 hold on pin 7
        irq_in[7] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 early", {31'd0, msi_valid}, 32'd0);
        @(negedge clk);
        chk("R9 due", {31'd0, msi_valid}, 32'd1);
        repeat (3) @(negedge clk);
        chk("R7 held valid", {31'd0, msi_valid}, 32'd1);
        chk("R7 payload", {10'd0, msi_data}, {10'd0, msgv(7)});
        chk("R7 doorbell", msi_addr, DB);
        get_msg(d, ok);
        // R4 merged edges
        irq_in[7] = 1'b0; repeat (2) @(negedge clk);
        irq_in[7] = 1'b1;
        quiet("R4 merged edge", 12);
        rd(clr_addr(7), r); chk("R4 pending kept", r & clr_bit(7), clr_bit(7));
        wr(clr_addr(7), clr_bit(7));
        rd(clr_addr(7), r); chk("R6 cleared", r & clr_bit(7), 32'd0);
        quiet("R4 no edge after clear", 8);
        irq_in[7] = 1'b0;

        // R6 zero write has no effect
        irq_in[9] = 1'b1;
        get_msg(d, ok);
        chk("R4 pin9", {10'd0, d}, {10'd0, msgv(9)});
        irq_in[9] = 1'b0;
        wr(clr_addr(9), ~clr_bit(9) & 32'h0);
        rd(clr_addr(9), r); chk("R6 zero write", r & clr_bit(9), clr_bit(9));
        wr(clr_addr(9), clr_bit(9));

        // R5 level pins, R3 type bit position
        for (int s = 0; s < 2; s++) begin
            int p = (s == 0) ? 77 : 200;
            wr(type_addr(p), 32'd1 << (p % 32));
            irq_in[p] = 1'b1;
            get_msg(d, ok);
            chk("R5 R3 level message", {9'd0, ok, d}, {9'd0, 1'b1, msgv(p)});
            quiet("R5 no repeat", 12);
            wr(clr_addr(p), clr_bit(p));
            get_msg(d, ok);
            chk("R5 resend after clear", {9'd0, ok, d}, {9'd0, 1'b1, msgv(p)});
            irq_in[p] = 1'b0;
            repeat (4) @(negedge clk);
            wr(clr_addr(p), clr_bit(p));
            quiet("R5 low after clear", 10);
            wr(type_addr(p), 32'd0);
        end

        // R6/R7 exhaustive per-pin delivery and clear mapping
        for (int i = 0; i < NPIN; i++) begin
            irq_in[i] = 1'b1;
            get_msg(d, ok);
            chk("R7 sweep payload", {9'd0, ok, d}, {9'd0, 1'b1, msgv(i)});
            irq_in[i] = 1'b0;
            wr(clr_addr(i), clr_bit(i));
            rd(clr_addr(i), r);
            chk("R6 sweep clear", r & clr_bit(i), 32'd0);
        end

        // R8 round robin: pointer is 0 after pin 255
        irq_in[150] = 1'b1;
        get_msg(d, ok);
        chk("R8 single", {10'd0, d}, {10'd0, msgv(150)});
        irq_in[150] = 1'b0; wr(clr_addr(150), clr_bit(150));
        order = '{160, 230, 40};
        irq_in[40] = 1'b1; irq_in[160] = 1'b1; irq_in[230] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            get_msg(d, ok);
            chk("R8 wrap order", {10'd0, d}, {10'd0, msgv(order[k])});
        end
        irq_in = '0;
        for (int k = 0; k < 3; k++) wr(clr_addr(order[k]), clr_bit(order[k]));
        order = '{41, 100, 5};
        irq_in[5] = 1'b1; irq_in[41] = 1'b1; irq_in[100] = 1'b1;
        for (int k = 0; k < 3; k++) begin
            get_msg(d, ok);
            chk("R8 pointer order", {10'd0, d}, {10'd0, msgv(order[k])});
        end
        quiet("R8 no extra", 8);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule